// File: doc/BRIEF.md
# ADC Window Limit Monitor

This block sits beside an analog-to-digital converter and watches every finished 10-bit conversion. Four identical limit slots each name one channel and carry a high threshold, a low threshold and separate enables for the two checks. When a result on a slot's channel lies above its enabled high threshold or below its enabled low threshold, a shared sticky flag is set. A single registered interrupt line is raised while a set flag has its own interrupt enable.

Software programs the slots and the interrupt enables through a small register port. It clears flags by writing ones to them, and it reads back the channel number and the data word of the most recent conversion to find which input went out of range. Slot writes are accepted only while the converter reports itself idle.

Top module: `adc_window_monitor`

## Requirements
- R1: Slot k (k = 0..3) sits at address 4+k and reads back as written, with the high threshold in bits [9:0], the low threshold in [19:10], the channel in [23:20], the high enable in bit 24 and the low enable in bit 25.
- R2: A conversion whose channel equals a slot's channel and whose value is strictly greater than that slot's high threshold, with the high enable set, sets the high flag (bit 0 of address 2).
- R3: A conversion whose channel equals a slot's channel and whose value is strictly less than that slot's low threshold, with the low enable set, sets the low flag (bit 1 of address 2).
- R4: A conversion sets no flag through a slot whose check is disabled or whose channel differs, and values equal to a threshold never trip it.
- R5: Flags are sticky. Writing 1 to a flag bit at address 2 clears that flag, and writing 0 leaves it unchanged.
- R6: When a trip and a clear of the same flag land in the same cycle, the flag ends up set.
- R7: The interrupt enables sit at address 3 (bit 0 high, bit 1 low). The registered `irq` output is high exactly when (high flag and bit 0) or (low flag and bit 1), and it is updated on the same edge as the flags.
- R8: Every conversion-done strobe stores its channel in address 0 bits [3:0] and its value in address 1 bits [9:0]. Address 0 bit 8 shows the live converter-busy input.
- R9: A slot write made while `conv_busy` is high is dropped.
- R10: After reset every register reads zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| conv_busy | input | 1 | Converter is mid-conversion |
| conv_done | input | 1 | One-cycle strobe carrying a finished result |
| conv_chan | input | 4 | Channel of the finished result |
| conv_data | input | 10 | Finished conversion value |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Limit interrupt, registered level |

## Verification
The main check runs every value from 0 to 1023 on eight channels against four slots set up differently: one with both checks enabled, one with only the high check, one with only the low check, and one with both checks disabled but thresholds that every value would break. Running through every value covers each threshold, the values one above and one below it, and the values equal to it. This separates strict comparisons from inclusive ones. Channels that match no slot, and the disabled slot, show that channel selection and enables both gate the flags. Separate directed patterns cover a clear landing together with a trip, interrupt-enable masking in each combination, and slot writes made while the converter is busy.

// File: rtl/adc_mon_pkg.sv
package adc_mon_pkg;
    localparam int DATA_W    = 10;
    localparam int CH_W      = 4;
    localparam int NUM_SLOTS = 4;
    localparam int REG_W     = 32;
    localparam int SLOT_BASE = 4;
    localparam int ADDR_W    = $clog2(SLOT_BASE + NUM_SLOTS);

    localparam logic [ADDR_W-1:0] A_CHAN  = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_DATA  = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_FLAGS = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_IE    = ADDR_W'(3);
    localparam int BUSY_BIT = 8;

    // packed from MSB: lo_en(25) hi_en(24) chan(23:20) lo(19:10) hi(9:0)
    typedef struct packed {
        logic              lo_en;
        logic              hi_en;
        logic [CH_W-1:0]   chan;
        logic [DATA_W-1:0] lo;
        logic [DATA_W-1:0] hi;
    } slot_t;

    localparam int SLOT_BITS = $bits(slot_t);

    typedef struct packed {
        logic [1:0] flags;
        logic [1:0] ie;
        logic       irq;
    } flag_state_t;
endpackage

// File: rtl/adc_mon_slot_cmp.sv
module adc_mon_slot_cmp
    import adc_mon_pkg::*;
(
    input  slot_t             cfg,
    input  logic              valid,
    input  logic [CH_W-1:0]   chan,
    input  logic [DATA_W-1:0] value,
    output logic              hi_hit,
    output logic              lo_hit
);
    logic match;

    always_comb begin
        match  = valid && (chan == cfg.chan);
        hi_hit = match && cfg.hi_en && (value > cfg.hi);
        lo_hit = match && cfg.lo_en && (value < cfg.lo);
    end
endmodule

// File: rtl/adc_mon_flags.sv
module adc_mon_flags
    import adc_mon_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] set_i,
    input  logic [1:0] clr_i,
    input  logic       ie_we,
    input  logic [1:0] ie_wdata,
    output logic [1:0] flags_o,
    output logic [1:0] ie_o,
    output logic       irq_o
);
    flag_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        // a trip in the same cycle overrides the clear
        st_d.flags = (st_q.flags & ~clr_i) | set_i;
        if (ie_we) begin
            st_d.ie = ie_wdata;
        end
        st_d.irq = |(st_d.flags & st_d.ie);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
    assign ie_o    = st_q.ie;
    assign irq_o   = st_q.irq;
endmodule

// File: rtl/adc_window_monitor.sv
module adc_window_monitor
    import adc_mon_pkg::*;
#(
    parameter int N_SLOTS = adc_mon_pkg::NUM_SLOTS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_busy,
    input  logic              conv_done,
    input  logic [CH_W-1:0]   conv_chan,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    output logic              irq
);
    typedef struct packed {
        slot_t [N_SLOTS-1:0] slots;
        logic [CH_W-1:0]     last_chan;
        logic [DATA_W-1:0]   last_data;
    } mon_state_t;

    mon_state_t st_d, st_q;

    logic [N_SLOTS-1:0]  hi_hits, lo_hits;
    logic [1:0]          flags_w, ie_w, clr_w;
    slot_t [N_SLOTS-1:0] slots_w;

    generate
        for (genvar k = 0; k < N_SLOTS; k++) begin : g_slot
            adc_mon_slot_cmp u_cmp (
                .cfg    (st_q.slots[k]),
                .valid  (conv_done),
                .chan   (conv_chan),
                .value  (conv_data),
                .hi_hit (hi_hits[k]),
                .lo_hit (lo_hits[k])
            );
        end
    endgenerate

    assign clr_w = (reg_we && reg_addr == A_FLAGS) ? reg_wdata[1:0] : 2'b00;

    adc_mon_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_i    ({|lo_hits, |hi_hits}),
        .clr_i    (clr_w),
        .ie_we    (reg_we && reg_addr == A_IE),
        .ie_wdata (reg_wdata[1:0]),
        .flags_o  (flags_w),
        .ie_o     (ie_w),
        .irq_o    (irq)
    );

    always_comb begin
        st_d = st_q;
        if (conv_done) begin
            st_d.last_chan = conv_chan;
            st_d.last_data = conv_data;
        end
        for (int k = 0; k < N_SLOTS; k++) begin
            if (reg_we && !conv_busy && (int'(reg_addr) == SLOT_BASE + k)) begin
                st_d.slots[k] = reg_wdata[SLOT_BITS-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_CHAN: begin
                reg_rdata[CH_W-1:0] = st_q.last_chan;
                reg_rdata[BUSY_BIT] = conv_busy;
            end
            A_DATA:  reg_rdata[DATA_W-1:0] = st_q.last_data;
            A_FLAGS: reg_rdata[1:0] = flags_w;
            A_IE:    reg_rdata[1:0] = ie_w;
            default: begin
                for (int k = 0; k < N_SLOTS; k++) begin
                    if (int'(reg_addr) == SLOT_BASE + k) begin
                        reg_rdata[SLOT_BITS-1:0] = st_q.slots[k];
                    end
                end
            end
        endcase
    end

    assign slots_w = st_q.slots;
endmodule

// File: rtl/adc_mon_chk.sv
module adc_mon_chk
    import adc_mon_pkg::*;
#(
    parameter int N_SLOTS = adc_mon_pkg::NUM_SLOTS
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic                          conv_busy,
    input logic                          conv_done,
    input logic [CH_W-1:0]               conv_chan,
    input logic                          reg_we,
    input logic [ADDR_W-1:0]             reg_addr,
    input logic [REG_W-1:0]              reg_wdata,
    input logic [1:0]                    flags,
    input logic [1:0]                    ie,
    input logic                          irq,
    input logic [CH_W-1:0]               last_chan,
    input logic [N_SLOTS*SLOT_BITS-1:0]  slots
);
    logic hi_clear_wr;
    assign hi_clear_wr = reg_we && (reg_addr == A_FLAGS) && reg_wdata[0];

    // R5
    hi_flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flags[0] && !hi_clear_wr) |=> flags[0]);

    // R2
    hi_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[0]) |-> $past(conv_done));

    // R3
    lo_flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[1]) |-> $past(conv_done));

    // R7
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> |(flags & ie));

    // R7
    irq_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        |(flags & ie) |-> irq);

    // R8
    last_chan_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done |=> (last_chan == $past(conv_chan)));

    // R9
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |=> $stable(slots));
endmodule

bind adc_window_monitor adc_mon_chk #(.N_SLOTS(N_SLOTS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_busy (conv_busy),
    .conv_done (conv_done),
    .conv_chan (conv_chan),
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .flags     (flags_w),
    .ie        (ie_w),
    .irq       (irq),
    .last_chan (st_q.last_chan),
    .slots     (slots_w)
);

// File: tb/adc_window_monitor_tb.sv
`timescale 1ns/1ps
module adc_window_monitor_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_busy = 1'b0;
    logic        conv_done = 1'b0;
    logic [3:0]  conv_chan = '0;
    logic [9:0]  conv_data = '0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_cmp = 0;
    int n_bad = 0;

    int cfg_hi [4] = '{600, 900, 100, 0};
    int cfg_lo [4] = '{200, 50, 1000, 1023};
    int cfg_ch [4] = '{2, 2, 5, 7};
    int cfg_he [4] = '{1, 1, 0, 0};
    int cfg_le [4] = '{1, 0, 1, 0};

    always #5 clk = ~clk;

    adc_window_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .conv_busy(conv_busy), .conv_done(conv_done),
        .conv_chan(conv_chan), .conv_data(conv_data), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        reg_addr = 3'(a);
        #1 d = reg_rdata;
    endtask

    task automatic conv(input int ch, input int v);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 4'(ch); conv_data = 10'(v);
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    function automatic logic [31:0] slot_word(input int k);
        return {6'd0, 1'(cfg_le[k]), 1'(cfg_he[k]), 4'(cfg_ch[k]),
                10'(cfg_lo[k]), 10'(cfg_hi[k])};
    endfunction

    function automatic logic [31:0] model_flags(input int ch, input int v);
        logic [31:0] f = '0;
        for (int k = 0; k < 4; k++) begin
            if (ch == cfg_ch[k]) begin
                if (cfg_he[k] != 0 && v > cfg_hi[k]) f[0] = 1'b1;
                if (cfg_le[k] != 0 && v < cfg_lo[k]) f[1] = 1'b1;
            end
        end
        return f;
    endfunction

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: reset state
        for (int a = 0; a < 8; a++) begin
            rd(a, r);
            check("R10 reset reg", r, 32'd0);
        end
        check("R10 reset irq", {31'd0, irq}, 32'd0);

        // R1: program and read back slots
        for (int k = 0; k < 4; k++) wr(4 + k, slot_word(k));
        for (int k = 0; k < 4; k++) begin
            rd(4 + k, r);
            check("R1 slot readback", r, slot_word(k));
        end

        // R2 R3 R4: full sweep of values over eight channels
        for (int ch = 0; ch < 8; ch++) begin
            for (int v = 0; v < 1024; v++) begin
                wr(2, 32'h3);
                conv(ch, v);
                rd(2, r);
                check("R2/R3/R4 flags", r, model_flags(ch, v));
            end
        end

        // R8: last channel and data, busy bit
        conv(5, 777);
        rd(0, r); check("R8 last chan", r, 32'd5);
        rd(1, r); check("R8 last data", r, 32'd777);
        conv_busy = 1'b1;
        rd(0, r); check("R8 busy bit", r, 32'h105);

        // R9: slot write while busy is dropped
        wr(4, 32'h0123_4567);
        rd(4, r); check("R9 busy write dropped", r, slot_word(0));
        conv_busy = 1'b0;

        // R5: sticky, write 1 clears, write 0 does nothing
        wr(2, 32'h3);
        conv(2, 1000);  // high trips on slot 0
        conv(2, 10);    // low trips on slot 0
        rd(2, r); check("R5 both flags set", r, 32'h3);
        wr(2, 32'h0);
        rd(2, r); check("R5 write 0 no effect", r, 32'h3);
        wr(2, 32'h1);
        rd(2, r); check("R5 clear high only", r, 32'h2);

        // R7: interrupt masking (low flag set, high clear)
        check("R7 irq masked by zero enables", {31'd0, irq}, 32'd0);
        wr(3, 32'h1);
        check("R7 irq high enable only", {31'd0, irq}, 32'd0);
        wr(3, 32'h2);
        check("R7 irq low enable", {31'd0, irq}, 32'd1);
        rd(3, r); check("R7 ie readback", r, 32'h2);
        wr(2, 32'h2);
        check("R7 irq drops after clear", {31'd0, irq}, 32'd0);

        // R6: trip and clear of the high flag in the same cycle
        wr(3, 32'h1);
        conv(2, 700);
        check("R7 irq on high trip", {31'd0, irq}, 32'd1);
        @(negedge clk);
        conv_done = 1'b1; conv_chan = 4'd2; conv_data = 10'd700;
        reg_we = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
        @(negedge clk);
        conv_done = 1'b0; reg_we = 1'b0;
        rd(2, r); check("R6 set wins over clear", r, 32'h1);
        check("R6 irq kept", {31'd0, irq}, 32'd1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule